// File: doc/BRIEF.md
# Double-Buffered Configuration Register Commit Controller

This block holds a bank of 32-bit configuration words in two copies. Software writes and reads a shadow copy through a simple memory-mapped port. The downstream logic only ever sees the active copy. The shadow copy moves into the active copy as a whole, in one clock edge, and only when a vertical-blank pulse arrives. A frame therefore never shows a mix of old and new settings.

A control word at its own address sets when the copy happens. Bit 0 is a load request and bit 1 disables autoload. With autoload disabled, a blank pulse copies the bank only while a load request is pending. The hardware clears the request in the same edge that performs the copy. Software polls bit 0 until it reads zero, and only then starts the next update. With autoload enabled, every blank pulse copies the bank.

Reset clears both copies and the control word, so read-modify-write sequences start from zero.

Top module: `shadow_commit_top`

## Requirements
- R1: After reset, every shadow word reads 0, every active word on `act_cfg` is 0, and the control word at 0x870 reads 0.
- R2: A write to a configuration address (base 0x800, word k at 0x800 + 4k, k < NUM_REGS) updates the shadow word. The new value can be read from the next cycle. `act_cfg` does not change.
- R3: While autoload is disabled (control bit 1 = 1) and no request is pending (control bit 0 = 0), a blank pulse leaves `act_cfg` unchanged.
- R4: When a blank pulse is sampled while a copy is enabled, every active word takes its shadow value on that clock edge. The result is visible on `act_cfg` in the following cycle.
- R5: Writing 1 to control bit 0 makes bit 0 read 1 until a copy takes place. The copy clears it in the same edge, so it reads 0 afterwards.
- R6: Writing 0 to control bit 0 does not cancel a pending request. Control bit 1 takes the written value.
- R7: With autoload enabled (control bit 1 = 0), every blank pulse copies the shadow bank, whatever bit 0 holds.
- R8: A request written in the same cycle as a blank pulse is not served by that pulse. It stays pending and is served by the next pulse.
- R9: An address that is neither a configuration word nor the control word reads 0 and ignores writes. This includes any address whose two low bits are not zero.
- R10: A shadow write in the same cycle as a copy leaves the old shadow value in the active word. The new value stays in the shadow word for the next copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_en | input | 1 | Write strobe for the register port |
| bus_addr | input | ADDR_W | Byte address, 4-byte aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| vblank | input | 1 | One-cycle vertical-blank pulse |
| act_cfg | output | NUM_REGS*32 | Active copy, word k at bits 32k+31:32k |

## Verification
A write reaches the shadow word and the control bits on the clock edge where it is sampled. Read data is combinational, so a read-back is due in the next low clock phase. A blank pulse sampled on an edge changes `act_cfg` and clears the request bit on that same edge, so both are due one cycle after the pulse.

The bench drives every input on the falling edge and samples half a period after each rising edge. Each result is checked in the exact cycle it is due. Checks that something must not change run one cycle after the pulse, which is where a wrong copy would first appear.

// File: rtl/shadow_commit_pkg.sv
package shadow_commit_pkg;

    localparam int WORD_W        = 32;
    localparam int LOAD_BIT      = 0;
    localparam int AUTO_DIS_BIT  = 1;

    typedef struct packed {
        logic auto_dis;
        logic load_req;
    } commit_ctrl_t;

    function automatic logic [WORD_W-1:0] status_word(input commit_ctrl_t c);
        logic [WORD_W-1:0] w;
        w = '0;
        w[LOAD_BIT]     = c.load_req;
        w[AUTO_DIS_BIT] = c.auto_dis;
        return w;
    endfunction

endpackage

// File: rtl/shadow_addr_decode.sv
module shadow_addr_decode #(
    parameter int ADDR_W    = 15,
    parameter int NUM_REGS  = 16,
    parameter int CFG_BASE  = 'h800,
    parameter int CTRL_ADDR = 'h870,
    parameter int IDX_W     = $clog2(NUM_REGS)
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit_cfg,
    output logic              hit_ctrl,
    output logic [IDX_W-1:0]  cfg_idx
);
    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(CFG_BASE);
    localparam logic [ADDR_W-1:0] END_A  = ADDR_W'(CFG_BASE + 4 * NUM_REGS);
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

    logic [ADDR_W-1:0] offset;
    logic              aligned;

    always_comb begin
        offset   = addr - BASE_A;
        aligned  = (addr[1:0] == 2'b00);
        hit_cfg  = aligned && (addr >= BASE_A) && (addr < END_A);
        hit_ctrl = (addr == CTRL_A);
        cfg_idx  = IDX_W'(offset >> 2);
    end

endmodule

// File: rtl/shadow_commit_ctrl.sv
module shadow_commit_ctrl
    import shadow_commit_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ctrl_wr,
    input  logic         wr_load,
    input  logic         wr_auto_dis,
    input  logic         vblank,
    output logic         commit,
    output commit_ctrl_t ctrl_q
);
    commit_ctrl_t ctrl_d;

    always_comb begin
        ctrl_d = ctrl_q;
        commit = vblank && (!ctrl_q.auto_dis || ctrl_q.load_req);
        if (commit) begin
            ctrl_d.load_req = 1'b0;
        end
        if (ctrl_wr) begin
            ctrl_d.auto_dis = wr_auto_dis;
            if (wr_load) begin
                ctrl_d.load_req = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    // R5: a served request is gone after the copy edge unless rewritten
    p_clear_on_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !(ctrl_wr && wr_load)) |=> !ctrl_q.load_req);

    // R6: a pending request survives any cycle without a copy
    p_keep_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.load_req && !vblank) |=> ctrl_q.load_req);

endmodule

// File: rtl/shadow_reg_bank.sv
module shadow_reg_bank
    import shadow_commit_pkg::*;
#(
    parameter int NUM_REGS = 16,
    parameter int IDX_W    = $clog2(NUM_REGS)
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  wr_en,
    input  logic [IDX_W-1:0]                      wr_idx,
    input  logic [WORD_W-1:0]                     wr_data,
    input  logic                                  commit,
    output logic [NUM_REGS-1:0][WORD_W-1:0]       shadow_q,
    output logic [NUM_REGS-1:0][WORD_W-1:0]       active_q
);
    logic [NUM_REGS-1:0][WORD_W-1:0] shadow_d;
    logic [NUM_REGS-1:0][WORD_W-1:0] active_d;

    for (genvar k = 0; k < NUM_REGS; k++) begin : g_word
        always_comb begin
            shadow_d[k] = shadow_q[k];
            active_d[k] = active_q[k];
            if (commit) begin
                active_d[k] = shadow_q[k];
            end
            if (wr_en && (wr_idx == IDX_W'(k))) begin
                shadow_d[k] = wr_data;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                shadow_q[k] <= '0;
                active_q[k] <= '0;
            end else begin
                shadow_q[k] <= shadow_d[k];
                active_q[k] <= active_d[k];
            end
        end
    end

    // R4, R10: the copy takes the shadow contents present before the edge
    p_copy_whole_bank_r4: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (active_q == $past(shadow_q)));

    // R2: without a copy the active bank holds
    p_active_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(active_q));

endmodule

// File: rtl/shadow_commit_top.sv
module shadow_commit_top
    import shadow_commit_pkg::*;
#(
    parameter int ADDR_W    = 15,
    parameter int NUM_REGS  = 16,
    parameter int CFG_BASE  = 'h800,
    parameter int CTRL_ADDR = 'h870
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_wr_en,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [31:0]                bus_wdata,
    output logic [31:0]                bus_rdata,
    input  logic                       vblank,
    output logic [NUM_REGS*32-1:0]     act_cfg
);
    localparam int IDX_W = $clog2(NUM_REGS);

    logic                            hit_cfg;
    logic                            hit_ctrl;
    logic [IDX_W-1:0]                cfg_idx;
    logic                            commit;
    commit_ctrl_t                    ctrl_q;
    logic [NUM_REGS-1:0][WORD_W-1:0] shadow_q;
    logic [NUM_REGS-1:0][WORD_W-1:0] active_q;

    shadow_addr_decode #(
        .ADDR_W    (ADDR_W),
        .NUM_REGS  (NUM_REGS),
        .CFG_BASE  (CFG_BASE),
        .CTRL_ADDR (CTRL_ADDR),
        .IDX_W     (IDX_W)
    ) u_decode (
        .addr     (bus_addr),
        .hit_cfg  (hit_cfg),
        .hit_ctrl (hit_ctrl),
        .cfg_idx  (cfg_idx)
    );

    shadow_commit_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl_wr     (bus_wr_en && hit_ctrl),
        .wr_load     (bus_wdata[LOAD_BIT]),
        .wr_auto_dis (bus_wdata[AUTO_DIS_BIT]),
        .vblank      (vblank),
        .commit      (commit),
        .ctrl_q      (ctrl_q)
    );

    shadow_reg_bank #(
        .NUM_REGS (NUM_REGS),
        .IDX_W    (IDX_W)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_wr_en && hit_cfg),
        .wr_idx   (cfg_idx),
        .wr_data  (bus_wdata),
        .commit   (commit),
        .shadow_q (shadow_q),
        .active_q (active_q)
    );

    always_comb begin
        bus_rdata = '0;
        if (hit_cfg) begin
            bus_rdata = shadow_q[cfg_idx];
        end else if (hit_ctrl) begin
            bus_rdata = status_word(ctrl_q);
        end
    end

    for (genvar k = 0; k < NUM_REGS; k++) begin : g_out
        assign act_cfg[k*32 +: 32] = active_q[k];
    end

    // R3: request-only mode with nothing pending leaves the outputs alone
    p_idle_blank_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (vblank && ctrl_q.auto_dis && !ctrl_q.load_req) |=> $stable(act_cfg));

    // R7: autoload copies on every blank
    p_autoload_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (vblank && !ctrl_q.auto_dis) |=> (active_q == $past(shadow_q)));

    // R9: writes to unmapped addresses leave the shadow bank untouched
    p_unmapped_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && !hit_cfg && !hit_ctrl) |=> $stable(shadow_q));

endmodule

// File: tb/shadow_commit_top_test.sv
module shadow_commit_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 15;
    localparam int N          = 16;
    localparam int BASE       = 'h800;
    localparam int CTRL       = 'h870;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr_en = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              vblank = 1'b0;
    logic [N*32-1:0]   act_cfg;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] exp_sh  [N];
    logic [31:0] exp_act [N];

    always #(CLK_PERIOD/2) clk = ~clk;

    shadow_commit_top #(
        .ADDR_W(ADDR_W), .NUM_REGS(N), .CFG_BASE(BASE), .CTRL_ADDR(CTRL)
    ) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .vblank(vblank),
        .act_cfg(act_cfg)
    );

    function automatic logic [ADDR_W-1:0] cfg_a(input int k);
        return ADDR_W'(BASE + 4 * k);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [ADDR_W-1:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic blank(input logic copies);
        @(negedge clk);
        vblank = 1'b1;
        @(negedge clk);
        vblank = 1'b0;
        if (copies) begin
            for (int k = 0; k < N; k++) exp_act[k] = exp_sh[k];
        end
    endtask

    task automatic check_active(input string req);
        logic ok;
        ok = 1'b1;
        for (int k = 0; k < N; k++) begin
            if (act_cfg[k*32 +: 32] !== exp_act[k]) begin
                ok = 1'b0;
                $display("FAIL %s: word %0d got %08h expected %08h",
                         req, k, act_cfg[k*32 +: 32], exp_act[k]);
            end
        end
        n_checks++;
        if (!ok) n_fail++;
    endtask

    task automatic wr_cfg(input int k, input logic [31:0] d);
        wr(cfg_a(k), d);
        exp_sh[k] = d;
    endtask

    task automatic t_reset;
        for (int k = 0; k < N; k++) begin exp_sh[k] = '0; exp_act[k] = '0; end
        rd_check("R1 shadow word 0", cfg_a(0), 32'h0);
        rd_check("R1 shadow last word", cfg_a(N-1), 32'h0);
        rd_check("R1 control word", ADDR_W'(CTRL), 32'h0);
        check_active("R1 active bank");
    endtask

    task automatic t_shadow_write;
        for (int k = 0; k < N; k++) wr_cfg(k, 32'hA500_0000 + k * 32'h0101);
        rd_check("R2 shadow read-back word 0", cfg_a(0), exp_sh[0]);
        rd_check("R2 shadow read-back word 7", cfg_a(7), exp_sh[7]);
        rd_check("R2 shadow read-back last", cfg_a(N-1), exp_sh[N-1]);
        check_active("R2 active unchanged by shadow writes");
    endtask

    task automatic t_request_only_idle;
        wr(ADDR_W'(CTRL), 32'h2);
        blank(1'b0);
        check_active("R3 blank without request");
        rd_check("R3 control bits", ADDR_W'(CTRL), 32'h2);
    endtask

    task automatic t_commit;
        wr(ADDR_W'(CTRL), 32'h3);
        rd_check("R5 request pending", ADDR_W'(CTRL), 32'h3);
        blank(1'b1);
        check_active("R4 whole bank copied");
        rd_check("R5 request cleared by hardware", ADDR_W'(CTRL), 32'h2);
        blank(1'b0);
        check_active("R3 second blank idle");
    endtask

    task automatic t_no_cancel;
        wr_cfg(0, 32'h1234_5678);
        wr(ADDR_W'(CTRL), 32'h3);
        wr(ADDR_W'(CTRL), 32'h2);
        rd_check("R6 zero does not cancel", ADDR_W'(CTRL), 32'h3);
        blank(1'b1);
        check_active("R6 pending request served");
        wr(ADDR_W'(CTRL), 32'h1);
        rd_check("R6 autoload bit follows write", ADDR_W'(CTRL), 32'h1);
    endtask

    task automatic t_autoload;
        blank(1'b1);
        rd_check("R7 request consumed", ADDR_W'(CTRL), 32'h0);
        wr_cfg(1, 32'hDEAD_BEEF);
        blank(1'b1);
        check_active("R7 autoload copy without request");
        wr_cfg(1, 32'h0BAD_F00D);
        blank(1'b1);
        check_active("R7 autoload copy again");
    endtask

    task automatic t_same_cycle_request;
        wr(ADDR_W'(CTRL), 32'h2);
        wr_cfg(2, 32'h5555_AAAA);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_addr = ADDR_W'(CTRL); bus_wdata = 32'h3; vblank = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0; vblank = 1'b0;
        check_active("R8 late request not served by same blank");
        rd_check("R8 request still pending", ADDR_W'(CTRL), 32'h3);
        blank(1'b1);
        check_active("R8 request served by next blank");
        rd_check("R8 request cleared", ADDR_W'(CTRL), 32'h2);
    endtask

    task automatic t_unmapped;
        wr(ADDR_W'(BASE + 4 * N), 32'hFFFF_FFFF);
        wr(ADDR_W'(BASE + 2), 32'hFFFF_FFFF);
        wr(ADDR_W'('h5800), 32'hFFFF_FFFF);
        rd_check("R9 past end reads zero", ADDR_W'(BASE + 4 * N), 32'h0);
        rd_check("R9 misaligned reads zero", ADDR_W'(BASE + 2), 32'h0);
        rd_check("R9 high address reads zero", ADDR_W'('h5800), 32'h0);
        rd_check("R9 word 0 untouched", cfg_a(0), exp_sh[0]);
        rd_check("R9 control untouched", ADDR_W'(CTRL), 32'h2);
        wr(ADDR_W'(CTRL), 32'h3);
        blank(1'b1);
        check_active("R9 bank unchanged by unmapped writes");
    endtask

    task automatic t_write_during_copy;
        wr(ADDR_W'(CTRL), 32'h3);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_addr = cfg_a(3); bus_wdata = 32'hC0FF_EE00; vblank = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0; vblank = 1'b0;
        for (int k = 0; k < N; k++) exp_act[k] = exp_sh[k];
        exp_sh[3] = 32'hC0FF_EE00;
        check_active("R10 copy takes pre-write shadow");
        rd_check("R10 new value in shadow", cfg_a(3), 32'hC0FF_EE00);
        wr(ADDR_W'(CTRL), 32'h3);
        blank(1'b1);
        check_active("R10 new value on next copy");
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_shadow_write();
        t_request_only_idle();
        t_commit();
        t_no_cancel();
        t_autoload();
        t_same_cycle_request();
        t_unmapped();
        t_write_during_copy();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule